// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Detector

This block watches a one-bit serial stream, taking one bit on every rising clock edge. It raises a one-bit flag during the same cycle in which the last bit of the pattern 1101 is on the input. The flag is a Mealy output: it depends on the current state and on the live input, so no extra register delay is added.

Matches may overlap. After a hit, the machine returns to the state that has seen a single 1. This means the closing 1 of one match can also open the next match. The design uses four states held in a 2-bit register, and a synchronous active-high reset.

Top module: `seq1101_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the machine goes to idle. In the cycle after reset is released, a 1 on `x` does not raise `y`.
- R2: From idle, a 1 moves to the seen-"1" state and a 0 stays in idle. A stream of 0s never raises `y`.
- R3: From seen-"1", a 1 moves to seen-"11" and a 0 returns to idle. So "10" followed by "1101" gives exactly one pulse, on the final bit.
- R4: From seen-"11", a 1 stays in seen-"11" and a 0 moves to seen-"110". So any run of two or more 1s, then 0, then 1, gives a pulse on that final 1.
- R5: In seen-"110" with `x`=1, `y` is 1 in that same cycle and the next state is seen-"1". A following "101" therefore gives a second pulse.
- R6: In seen-"110" with `x`=0, `y` stays 0 and the machine returns to idle. So "1100" followed by "1" gives no pulse.
- R7: `y` is 0 for every other state and input combination. After reset has been low for at least three samples, `y` is high exactly when the last four sampled bits, oldest first, are 1,1,0,1.
- R8: The stream 1101101, applied after reset, gives pulses on the 4th and 7th bits only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| x | input | 1 | Serial data bit |
| y | output | 1 | Match flag, high during the cycle the closing 1 is present |

## Verification
A wrong state is visible only through `y`. It appears at the latest on the next 1 that completes, or wrongly seems to complete, a 1101 window. That is at most four cycles after the error for a missed or spurious pulse. The bench keeps a four-bit history of the stream and predicts `y` for every cycle. This includes long runs of 1s, a broken "1100", and back-to-back overlapping matches. An error in a single transition therefore shows up as a pulse mismatch within a few bits.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

    localparam int unsigned STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 2'd0,
        ST_GOT1   = 2'd1,
        ST_GOT11  = 2'd2,
        ST_GOT110 = 2'd3
    } det_state_e;

    // Next state for the given current state and serial bit.
    function automatic det_state_e step_f(input det_state_e cur, input logic bit_in);
        det_state_e nxt;
        case (cur)
            ST_IDLE:   nxt = bit_in ? ST_GOT1  : ST_IDLE;
            ST_GOT1:   nxt = bit_in ? ST_GOT11 : ST_IDLE;
            ST_GOT11:  nxt = bit_in ? ST_GOT11 : ST_GOT110;
            ST_GOT110: nxt = bit_in ? ST_GOT1  : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

    // Mealy flag: the closing 1 arrives while three bits are already matched.
    function automatic logic hit_f(input det_state_e cur, input logic bit_in);
        logic h;
        case (cur)
            ST_GOT110: h = bit_in;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
    import seqdet_pkg::*;
(
    input  det_state_e cur_state,
    input  logic       bit_in,
    output det_state_e nxt_state
);
    always_comb begin
        nxt_state = step_f(cur_state, bit_in);
    end
endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
    import seqdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  det_state_e nxt_state,
    output det_state_e cur_state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= ST_IDLE;
        end else begin
            cur_state <= nxt_state;
        end
    end
endmodule

// File: rtl/seqdet_out.sv
module seqdet_out
    import seqdet_pkg::*;
(
    input  det_state_e cur_state,
    input  logic       bit_in,
    output logic       hit
);
    always_comb begin
        hit = hit_f(cur_state, bit_in);
    end
endmodule

// File: rtl/seq1101_detector.sv
module seq1101_detector
    import seqdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    output logic y
);
    det_state_e cur_state;
    det_state_e nxt_state;

    seqdet_next u_next (
        .cur_state (cur_state),
        .bit_in    (x),
        .nxt_state (nxt_state)
    );

    seqdet_state_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    seqdet_out u_out (
        .cur_state (cur_state),
        .bit_in    (x),
        .hit       (y)
    );
endmodule

// File: rtl/seq1101_detector_chk.sv
module seq1101_detector_chk
    import seqdet_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       x,
    input logic       y,
    input det_state_e state
);
    // Number of bits sampled since reset was released, saturating at 3.
    logic [1:0] seen_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_cnt <= 2'd0;
        end else if (seen_cnt != 2'd3) begin
            seen_cnt <= seen_cnt + 2'd1;
        end
    end

    AST_RESET_TO_IDLE: assert property (@(posedge clk) rst |=> state == ST_IDLE); // R1
    AST_IDLE_HOLD:     assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE && !x) |=> state == ST_IDLE); // R2
    AST_IDLE_ADVANCE:  assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE && x) |=> state == ST_GOT1); // R2
    AST_ONE_STEP:      assert property (@(posedge clk) disable iff (rst) (state == ST_GOT1) |=> state == ($past(x) ? ST_GOT11 : ST_IDLE)); // R3
    AST_TWO_STEP:      assert property (@(posedge clk) disable iff (rst) (state == ST_GOT11) |=> state == ($past(x) ? ST_GOT11 : ST_GOT110)); // R4
    AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (rst) y |=> state == ST_GOT1); // R5
    AST_MISS_CLEAR:    assert property (@(posedge clk) disable iff (rst) (state == ST_GOT110 && !x) |=> state == ST_IDLE); // R6
    AST_EARLY_QUIET:   assert property (@(posedge clk) disable iff (rst) (seen_cnt != 2'd3) |-> !y); // R7
    AST_DETECT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (seen_cnt == 2'd3) |-> (y == (x && !$past(x) && $past(x, 2) && $past(x, 3)))); // R7
endmodule

bind seq1101_detector seq1101_detector_chk i_chk (
    .clk   (clk),
    .rst   (rst),
    .x     (x),
    .y     (y),
    .state (cur_state)
);

// File: tb/test_seq1101_detector.sv
`timescale 1ns/1ps
module test_seq1101_detector;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x   = 1'b0;
    logic y;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0] hist  = 4'd0;
    int         valid = 0;

    logic  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk; // 125 MHz

    seq1101_detector i_seq1101_detector (
        .clk (clk),
        .rst (rst),
        .x   (x),
        .y   (y)
    );

    // Drive one bit and queue the predicted flag for that cycle.
    task automatic send_bit(input logic b, input string tag);
        logic e;
        @(negedge clk);
        x = b;
        e = (valid >= 3) && ({hist[2:0], b} == 4'b1101);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        hist  = {hist[2:0], b};
        valid = valid + 1;
    endtask

    task automatic send_str(input string s, input string tag);
        for (int i = 0; i < s.len(); i++) begin
            send_bit(s[i] == "1", tag);
        end
    endtask

    // One reset cycle with x low; the flag must stay low.
    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1;
        x   = 1'b0;
        exp_q.push_back(1'b0);
        tag_q.push_back(tag);
        hist  = 4'd0;
        valid = 0;
        @(negedge clk);
        rst = 1'b0;
        exp_q.push_back(1'b0);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares y with the queued prediction, mid low phase.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() != 0) begin
                logic  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (y !== e) begin
                    errors++;
                    $display("FAIL %s: y=%0b expected %0b at %0t", t, y, e, $time);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        do_reset("R1");
        send_bit(1'b1, "R1");            // first bit after reset: no pulse
        do_reset("R1");
        send_str("1101101", "R8");         // pulses at bits 4 and 7
        do_reset("R2");
        send_str("000000", "R2");
        send_str("101101", "R3");
        do_reset("R4");
        send_str("1111101", "R4");
        send_str("1101101101", "R5");      // chained overlapping matches
        do_reset("R6");
        send_str("11001", "R6");
        send_str("1100", "R6");
        send_str("110", "R1");
        do_reset("R1");                    // reset mid-pattern forgets history
        send_bit(1'b1, "R1");
        send_str("0110111010011", "R7");
        for (int n = 0; n < 300; n++) begin
            send_bit(lfsr[0], "R7");
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule